// File: doc/BRIEF.md
# DMA Interrupt and Channel-Enable Register Block

This block holds the interrupt and channel-enable state of an eight-channel DMA controller. Each channel's datapath reports five kinds of event as single-cycle pulses: the whole chain finished, one block finished, a source-side transaction finished, a destination-side transaction finished, and an error response on the bus. Each event sets a sticky raw bit. A per-class mask selects which raw bits are visible as status. The OR of every visible bit, gated by a global enable bit, drives one interrupt line.

Software reaches all of this through a simple word-addressed register port. Writes take effect on the clock edge. Reads are combinational from the current state. The mask and channel-enable registers use a write-enable scheme: the upper byte of write data chooses which channel bits of the lower byte a write may change. Channel-enable bits also drop by themselves when a channel's chain completes, so software can poll them for completion.

Top module: `dma_irq_regs`

## Requirements
- R1: After reset, every raw, mask, channel-enable and configuration bit is 0, every mapped address reads 0, and `irq_o` is 0.
- R2: A pulse on an event input sets the raw bit for that class and channel (raw addresses 0..4 in class order chain, block, source, destination, error), whether or not its mask bit is set. The raw bit stays set until it is cleared.
- R3: The status register of a class (addresses 5..9) reads as that class's raw bits ANDed with its mask bits.
- R4: Writing to a clear register (addresses 15..19) clears every raw bit whose data bit is 1 and leaves raw bits whose data bit is 0 unchanged. Clear registers read as 0.
- R5: When an event pulse and a clear of the same bit happen in the same cycle, the bit ends up set.
- R6: A write to a mask register (addresses 10..14) updates only those bits 7:0 whose matching bit in 15:8 is 1. A mask register reads back with bits 31:8 at 0.
- R7: A write to the channel-enable register (address 22) follows the same rule as R6. `chan_en_o` and the readback show its bits 7:0, and bits 31:8 read as 0.
- R8: A chain-complete pulse clears that channel's enable bit. If a selected write to the same bit happens in the same cycle, the written value wins.
- R9: The summary register (address 20) has bit k set when any status bit of class k is set (k: 0 chain, 1 block, 2 source, 3 destination, 4 error). Its bits 31:5 read as 0.
- R10: `irq_o` is 1 exactly when configuration bit 0 is 1 and at least one status bit of any class is 1.
- R11: The configuration register (address 21) keeps bit 0 of the write data and reads every other bit as 0.
- R12: Writes to unmapped addresses (23..31) change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 5 | Word address of the register access |
| reg_wr_i | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| evt_chain_i | input | 8 | Chain-complete pulses, one per channel |
| evt_block_i | input | 8 | Block-complete pulses |
| evt_srctx_i | input | 8 | Source-transaction-done pulses |
| evt_dsttx_i | input | 8 | Destination-transaction-done pulses |
| evt_buserr_i | input | 8 | Bus-error pulses |
| chan_en_o | output | 8 | Channel-enable bits |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Checked on every cycle by the assertions:
- an event always leaves its raw bit set;
- a clear removes only the bits it names that were not hit by an event in the same cycle;
- without a clear, raw bits never drop;
- a selected write loads the written mask or enable value;
- an unopposed chain-complete pulse drops the enable bit;
- the interrupt never rises while the block is disabled globally.

Left to the bench scenarios:
- readback formats: upper bits read as zero, and clear registers read as zero;
- the exact value of the summary register;
- the address decode, including unmapped addresses;
- which side wins when an event or a chain completion meets a write in the same cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    // Interrupt classes; the index is also the summary bit position
    typedef enum logic [2:0] {
        CLS_CHAIN  = 3'd0,
        CLS_BLOCK  = 3'd1,
        CLS_SRCTX  = 3'd2,
        CLS_DSTTX  = 3'd3,
        CLS_BUSERR = 3'd4
    } irq_cls_e;

    localparam int NUM_CLS   = 5;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 32;

    // Word address map, derived from the class count
    localparam int RAW_BASE  = 0;
    localparam int STAT_BASE = RAW_BASE + NUM_CLS;
    localparam int MASK_BASE = STAT_BASE + NUM_CLS;
    localparam int CLR_BASE  = MASK_BASE + NUM_CLS;
    localparam int SUM_ADDR  = CLR_BASE + NUM_CLS;
    localparam int CFG_ADDR  = SUM_ADDR + 1;
    localparam int CHEN_ADDR = CFG_ADDR + 1;
endpackage

// File: rtl/dma_we_reg.sv
// Register written through a per-bit write-enable field held in the upper half of the write data
module dma_we_reg #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic [2*W-1:0] wdata_i,
    input  logic [W-1:0]   drop_i,
    output logic [W-1:0]   q_o
);
    logic [W-1:0] q_nxt;
    logic [W-1:0] sel;

    assign sel = wdata_i[2*W-1:W];

    always_comb begin
        q_nxt = q_o & ~drop_i;
        if (wr_i) begin
            q_nxt = (q_nxt & ~sel) | (wdata_i[W-1:0] & sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= q_nxt;
    end

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ((q_o & $past(sel)) == ($past(wdata_i[W-1:0]) & $past(sel)))); // R6

    AST_UNSEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_i == '0) |=> ((q_o & ~$past(sel & {W{wr_i}})) == ($past(q_o) & ~$past(sel & {W{wr_i}})))); // R7
endmodule

// File: rtl/dma_irq_class.sv
// One interrupt class: sticky raw bits, write-enabled mask and visible status
module dma_irq_class #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   evt_i,
    input  logic           clr_wr_i,
    input  logic           mask_wr_i,
    input  logic [2*W-1:0] wdata_i,
    output logic [W-1:0]   raw_o,
    output logic [W-1:0]   mask_o,
    output logic [W-1:0]   stat_o
);
    logic [W-1:0] clr_vec;

    assign clr_vec = clr_wr_i ? wdata_i[W-1:0] : '0;

    // An event in the same cycle as a clear leaves the bit set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_o <= '0;
        else        raw_o <= (raw_o & ~clr_vec) | evt_i;
    end

    dma_we_reg #(.W(W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mask_wr_i),
        .wdata_i (wdata_i),
        .drop_i  ({W{1'b0}}),
        .q_o     (mask_o)
    );

    assign stat_o = raw_o & mask_o;

    AST_RAW_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((raw_o & $past(evt_i)) == $past(evt_i))); // R2

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr_i |=> ((raw_o & $past(wdata_i[W-1:0] & ~evt_i)) == '0)); // R4

    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr_i |=> ((raw_o & $past(raw_o)) == $past(raw_o))); // R2
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
    import dma_irq_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic [NCH-1:0]    evt_chain_i,
    input  logic [NCH-1:0]    evt_block_i,
    input  logic [NCH-1:0]    evt_srctx_i,
    input  logic [NCH-1:0]    evt_dsttx_i,
    input  logic [NCH-1:0]    evt_buserr_i,
    output logic [NCH-1:0]    chan_en_o,
    output logic              irq_o
);
    localparam int WE_W = 2 * NCH;

    logic [NCH-1:0]     evt   [NUM_CLS];
    logic [NCH-1:0]     raw   [NUM_CLS];
    logic [NCH-1:0]     mask  [NUM_CLS];
    logic [NCH-1:0]     stat  [NUM_CLS];
    logic [NUM_CLS-1:0] any_stat;
    logic               cfg_en;
    logic               chen_wr;
    logic               wdata_unused;

    assign wdata_unused = ^reg_wdata_i[DATA_W-1:WE_W];

    assign evt[CLS_CHAIN]  = evt_chain_i;
    assign evt[CLS_BLOCK]  = evt_block_i;
    assign evt[CLS_SRCTX]  = evt_srctx_i;
    assign evt[CLS_DSTTX]  = evt_dsttx_i;
    assign evt[CLS_BUSERR] = evt_buserr_i;

    genvar k;
    generate
        for (k = 0; k < NUM_CLS; k++) begin : g_cls
            dma_irq_class #(.W(NCH)) u_cls (
                .clk       (clk),
                .rst_n     (rst_n),
                .evt_i     (evt[k]),
                .clr_wr_i  (reg_wr_i && reg_addr_i == ADDR_W'(CLR_BASE + k)),
                .mask_wr_i (reg_wr_i && reg_addr_i == ADDR_W'(MASK_BASE + k)),
                .wdata_i   (reg_wdata_i[WE_W-1:0]),
                .raw_o     (raw[k]),
                .mask_o    (mask[k]),
                .stat_o    (stat[k])
            );
            assign any_stat[k] = |stat[k];
        end
    endgenerate

    // Channel enable: selected writes load, chain completion drops
    assign chen_wr = reg_wr_i && reg_addr_i == ADDR_W'(CHEN_ADDR);

    dma_we_reg #(.W(NCH)) u_chen (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (chen_wr),
        .wdata_i (reg_wdata_i[WE_W-1:0]),
        .drop_i  (evt_chain_i),
        .q_o     (chan_en_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          cfg_en <= 1'b0;
        else if (reg_wr_i && reg_addr_i == ADDR_W'(CFG_ADDR)) cfg_en <= reg_wdata_i[0];
    end

    assign irq_o = cfg_en & (|any_stat);

    // Read mux; clear registers and unmapped addresses read zero
    always_comb begin
        reg_rdata_o = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (reg_addr_i == ADDR_W'(RAW_BASE + c))  reg_rdata_o[NCH-1:0] = raw[c];
            if (reg_addr_i == ADDR_W'(STAT_BASE + c)) reg_rdata_o[NCH-1:0] = stat[c];
            if (reg_addr_i == ADDR_W'(MASK_BASE + c)) reg_rdata_o[NCH-1:0] = mask[c];
        end
        if (reg_addr_i == ADDR_W'(SUM_ADDR))  reg_rdata_o[NUM_CLS-1:0] = any_stat;
        if (reg_addr_i == ADDR_W'(CFG_ADDR))  reg_rdata_o[0]           = cfg_en;
        if (reg_addr_i == ADDR_W'(CHEN_ADDR)) reg_rdata_o[NCH-1:0]     = chan_en_o;
    end

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> cfg_en); // R10

    AST_CHEN_SELF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_chain_i != '0) && !chen_wr) |=> ((chan_en_o & $past(evt_chain_i)) == '0)); // R8

    AST_CHAIN_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_chain_i != '0) |=> ((raw[CLS_CHAIN] & $past(evt_chain_i)) != '0)); // R2
endmodule

// File: tb/sim_dma_irq_regs.sv
module sim_dma_irq_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  ev_chain = '0, ev_block = '0, ev_src = '0, ev_dst = '0, ev_err = '0;
    logic [7:0]  chan_en;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    dma_irq_regs u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .evt_chain_i(ev_chain), .evt_block_i(ev_block), .evt_srctx_i(ev_src),
        .evt_dsttx_i(ev_dst), .evt_buserr_i(ev_err),
        .chan_en_o(chan_en), .irq_o(irq)
    );

    typedef struct packed {
        logic        is_wr;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] expv;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd10, 32'h0000_FF5A, 32'h0, 8'd6},   // R6 full select
        '{1'b0, 5'd10, 32'h0,         32'h5A, 8'd6},
        '{1'b1, 5'd10, 32'hFFFF_0F00, 32'h0, 8'd6},   // R6 low nibble only
        '{1'b0, 5'd10, 32'h0,         32'h50, 8'd6},
        '{1'b1, 5'd10, 32'h0000_00FF, 32'h0, 8'd6},   // R6 no select
        '{1'b0, 5'd10, 32'h0,         32'h50, 8'd6},
        '{1'b1, 5'd21, 32'hFFFF_FFFF, 32'h0, 8'd11},  // R11
        '{1'b0, 5'd21, 32'h0,         32'h1, 8'd11},
        '{1'b1, 5'd22, 32'hFFFF_0303, 32'h0, 8'd7},   // R7
        '{1'b0, 5'd22, 32'h0,         32'h03, 8'd7},
        '{1'b1, 5'd22, 32'h0000_0200, 32'h0, 8'd7},
        '{1'b0, 5'd22, 32'h0,         32'h01, 8'd7},
        '{1'b1, 5'd30, 32'hFFFF_FFFF, 32'h0, 8'd12},  // R12
        '{1'b0, 5'd30, 32'h0,         32'h0, 8'd12},
        '{1'b0, 5'd15, 32'h0,         32'h0, 8'd4},   // R4 clear reads zero
        '{1'b0, 5'd0,  32'h0,         32'h0, 8'd2}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] expv, input string req);
        reg_addr = a;
        #1;
        check(req, reg_rdata, expv);
    endtask

    task automatic pulse(input logic [7:0] c, input logic [7:0] b, input logic [7:0] e);
        @(negedge clk);
        ev_chain = c; ev_block = b; ev_err = e;
        @(negedge clk);
        ev_chain = '0; ev_block = '0; ev_err = '0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of every mapped address and of the outputs
        for (int a = 0; a < 23; a++) rd(5'(a), 32'h0, "R1");
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 chan_en", {24'b0, chan_en}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_wr) wr(VECS[i].addr, VECS[i].data);
            else rd(VECS[i].addr, VECS[i].expv, $sformatf("R%0d", VECS[i].req));
        end
        // ev_src/ev_dst stay quiet: R2 bench check for those classes
        rd(5'd2, 32'h0, "R2 src"); rd(5'd3, 32'h0, "R2 dst");

        // R2 R3 R9 R10: unmasked block events
        wr(5'd11, 32'h0000_FFFF);
        pulse(8'h00, 8'h81, 8'h00);
        rd(5'd1, 32'h81, "R2");
        rd(5'd6, 32'h81, "R3");
        rd(5'd20, 32'h02, "R9");
        check("R10 irq on", {31'b0, irq}, 32'h1);
        wr(5'd21, 32'h0);
        check("R10 irq gated", {31'b0, irq}, 32'h0);
        wr(5'd21, 32'h1);

        // R2: masked error event still latches, status hidden
        pulse(8'h00, 8'h00, 8'h10);
        rd(5'd4, 32'h10, "R2 masked");
        rd(5'd9, 32'h00, "R3 masked");
        rd(5'd20, 32'h02, "R9 masked");

        // R4: write-one-to-clear, zero no effect
        wr(5'd16, 32'h01);
        rd(5'd1, 32'h80, "R4 w1c");
        wr(5'd16, 32'h00);
        rd(5'd1, 32'h80, "R4 w0");
        rd(5'd16, 32'h0, "R4 read");

        // R5: event and clear together
        @(negedge clk);
        ev_block = 8'h80; reg_addr = 5'd16; reg_wdata = 32'h80; reg_wr = 1'b1;
        @(negedge clk);
        ev_block = '0; reg_wr = 1'b0;
        rd(5'd1, 32'h80, "R5");
        wr(5'd16, 32'h80);
        rd(5'd1, 32'h00, "R4 final");
        check("R10 irq off", {31'b0, irq}, 32'h0);

        // R8: chain completion drops enable, write wins on collision
        wr(5'd22, 32'h0000_FFFF);
        check("R7 all on", {24'b0, chan_en}, 32'hFF);
        pulse(8'h05, 8'h00, 8'h00);
        check("R8 self clear", {24'b0, chan_en}, 32'hFA);
        rd(5'd0, 32'h05, "R2 chain raw");
        @(negedge clk);
        ev_chain = 8'h01; reg_addr = 5'd22; reg_wdata = 32'h0101; reg_wr = 1'b1;
        @(negedge clk);
        ev_chain = '0; reg_wr = 1'b0;
        check("R8 write wins", {24'b0, chan_en}, 32'hFB);
        rd(5'd22, 32'hFB, "R7 readback");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule